// File: doc/BRIEF.md
# Interrupt Acknowledge Unit with Non-Maskable Support

This block sits between one CPU and the interrupt controller's pending-interrupt logic. Every cycle it sees the single most urgent pending interrupt: its ID, its priority, its group and a non-maskable flag. The CPU reads through three strobed ports. The normal port acknowledges an ordinary Group 1 interrupt. The non-maskable port acknowledges a Group 1 interrupt that carries the non-maskable flag. The peek port only reports the pending ID and changes nothing.

A successful acknowledge emits a single-cycle activation pulse with the interrupt ID, so the pending logic can mark that interrupt active. In the same cycle the block records the interrupt's priority level in an internal active-level vector, or sets an active non-maskable flag if the interrupt was non-maskable. From that state it derives the running priority. That value gates later acknowledges, so an interrupt must be strictly more urgent than everything already in service.

Top module: `irq_ack_unit`

## Requirements
- R1: A normal-port read of an eligible pending interrupt without the non-maskable flag returns its ID. The following cycle carries a one-cycle act_pulse with act_id equal to that ID.
- R2: A normal-port read of an eligible pending interrupt with the non-maskable flag returns 1022. It does not pulse act_pulse and does not change the running priority.
- R3: A non-maskable-port read of an eligible interrupt with the flag returns its ID and activates it. If the eligible interrupt lacks the flag, the read returns 1023 and nothing is activated.
- R4: A peek read returns the pending ID whatever the non-maskable flag is. It ignores the priority mask and the running priority, and never changes act_pulse or the running priority.
- R5: When pend_valid is 0, or pend_id is 1020 or higher, every port returns 1023.
- R6: Group codes are 0 = Group 0, 1 = Group 1 Secure, 2 = Group 1 Non-secure. The ports serve group 2 when cpu_ns=1 and group 1 when cpu_ns=0. With SECURITY=0, code 1 is treated as Group 0, and only code 2 is served. A group mismatch returns 1023.
- R7: An acknowledge requires pend_prio to be strictly below both pmr and rpr_prio (lower value means more urgent). Otherwise the port returns 1023.
- R8: rpr_prio is the most urgent acknowledged level, with the PRIO_W-PRI_BITS low bits cleared, or 0xFF when nothing has been acknowledged since reset.
- R9: A non-maskable acknowledge sets rpr_nmi=1 and forces rpr_prio to 0x00. After that, no further acknowledge succeeds.
- R10: With CPU_NMI=0, the non-maskable port always returns 1023. The normal port then ignores pend_nmi and acknowledges the interrupt normally.
- R11: Each port's valid output is high for exactly the cycle after its strobe, with the registered ID. After reset, all valids and act_pulse are 0, rpr_prio is 0xFF and rpr_nmi is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ns | input | 1 | CPU runs in non-secure state |
| pmr | input | 8 | Priority mask |
| pend_valid | input | 1 | A pending interrupt is presented |
| pend_id | input | ID_W | Pending interrupt ID |
| pend_prio | input | PRIO_W | Pending interrupt priority |
| pend_grp | input | 2 | Pending interrupt group code |
| pend_nmi | input | 1 | Pending interrupt is non-maskable |
| rd_ack | input | 1 | Normal acknowledge read strobe |
| rd_nmi | input | 1 | Non-maskable acknowledge read strobe |
| rd_peek | input | 1 | Peek read strobe |
| ack_vld | output | 1 | Normal port result valid |
| ack_id | output | ID_W | Normal port result |
| nmi_vld | output | 1 | Non-maskable port result valid |
| nmi_id | output | ID_W | Non-maskable port result |
| peek_vld | output | 1 | Peek result valid |
| peek_id | output | ID_W | Peek result |
| act_pulse | output | 1 | Activate request |
| act_id | output | ID_W | ID to activate |
| rpr_prio | output | PRIO_W | Running priority |
| rpr_nmi | output | 1 | Running priority is non-maskable |

## Verification
Two pairs of operations can collide in one cycle. The first is a peek and an acknowledge on the same pending interrupt: the peek must report the ID as it stood before the acknowledge, while the acknowledge activates the interrupt and lowers the running priority. The second is both acknowledge ports strobed together on one interrupt, where the flag must steer the result: one port returns the ID and the other returns its reserved value. The bench drives these strobes in the same cycle and checks every port's result, the activation and the running priority against a reference model of the requirements. A second instance built without security or non-maskable support runs alongside on the same stimulus.

// File: rtl/irq_ack_unit.sv
module irq_ack_unit #(
  parameter int ID_W     = 10,
  parameter int PRIO_W   = 8,
  parameter int PRI_BITS = 5,
  parameter bit SECURITY = 1'b1,
  parameter bit CPU_NMI  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_ns,
  input  logic [PRIO_W-1:0] pmr,
  input  logic              pend_valid,
  input  logic [ID_W-1:0]   pend_id,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [1:0]        pend_grp,
  input  logic              pend_nmi,
  input  logic              rd_ack,
  input  logic              rd_nmi,
  input  logic              rd_peek,
  output logic              ack_vld,
  output logic [ID_W-1:0]   ack_id,
  output logic              nmi_vld,
  output logic [ID_W-1:0]   nmi_id,
  output logic              peek_vld,
  output logic [ID_W-1:0]   peek_id,
  output logic              act_pulse,
  output logic [ID_W-1:0]   act_id,
  output logic [PRIO_W-1:0] rpr_prio,
  output logic              rpr_nmi
);
  localparam int LOW  = PRIO_W - PRI_BITS;
  localparam int NLVL = 1 << PRI_BITS;
  localparam logic [ID_W-1:0] ID_NONE  = ID_W'(1023);
  localparam logic [ID_W-1:0] ID_NMISP = ID_W'(1022);
  localparam logic [ID_W-1:0] ID_SPEC  = ID_W'(1020);

  logic [NLVL-1:0]     apr;
  logic                apr_nmi;
  logic [PRIO_W-1:0]   lvl_prio;
  logic [1:0]          grp_eff, grp_tgt;
  logic                avail, prio_ok, nmi_eff, take_n, take_m;
  logic [PRI_BITS-1:0] lvl;

  assign grp_eff = (!SECURITY && pend_grp == 2'd1) ? 2'd0 : pend_grp;
  assign grp_tgt = (SECURITY && !cpu_ns) ? 2'd1 : 2'd2;
  assign avail   = pend_valid && (pend_id < ID_SPEC) && (grp_eff == grp_tgt);

  always_comb begin
    lvl_prio = '1;
    for (int i = NLVL - 1; i >= 0; i--)
      if (apr[i]) lvl_prio = PRIO_W'(i) << LOW;
  end

  assign rpr_prio = apr_nmi ? '0 : lvl_prio;
  assign rpr_nmi  = apr_nmi;
  assign prio_ok  = (pend_prio < pmr) && (pend_prio < rpr_prio);
  assign nmi_eff  = CPU_NMI && pend_nmi;
  assign take_n   = rd_ack && avail && prio_ok && !nmi_eff;
  assign take_m   = rd_nmi && CPU_NMI && avail && prio_ok && nmi_eff;
  assign lvl      = pend_prio[PRIO_W-1:LOW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_vld   <= 1'b0;
      ack_id    <= ID_NONE;
      nmi_vld   <= 1'b0;
      nmi_id    <= ID_NONE;
      peek_vld  <= 1'b0;
      peek_id   <= ID_NONE;
      act_pulse <= 1'b0;
      act_id    <= '0;
      apr       <= '0;
      apr_nmi   <= 1'b0;
    end else begin
      ack_vld   <= rd_ack;
      nmi_vld   <= rd_nmi;
      peek_vld  <= rd_peek;
      act_pulse <= take_n || take_m;
      if (rd_ack)
        ack_id <= !(avail && prio_ok) ? ID_NONE : (nmi_eff ? ID_NMISP : pend_id);
      if (rd_nmi)
        nmi_id <= (avail && prio_ok && nmi_eff) ? pend_id : ID_NONE;
      if (rd_peek)
        peek_id <= avail ? pend_id : ID_NONE;
      if (take_n || take_m) act_id <= pend_id;
      if (take_n) apr[lvl] <= 1'b1;
      if (take_m) apr_nmi <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_ack_unit_chk.sv
module irq_ack_unit_chk #(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_ack,
  input logic              rd_nmi,
  input logic              rd_peek,
  input logic              ack_vld,
  input logic [ID_W-1:0]   ack_id,
  input logic              nmi_vld,
  input logic [ID_W-1:0]   nmi_id,
  input logic              act_pulse,
  input logic [ID_W-1:0]   act_id,
  input logic [PRIO_W-1:0] rpr_prio,
  input logic              rpr_nmi
);
  // R11
  act_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_pulse |-> $past(rd_ack || rd_nmi));
  // R1
  act_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_pulse |-> act_id < ID_W'(1020));
  // R2
  nmisp_noact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && ack_id == ID_W'(1022) && !nmi_vld) |-> !act_pulse);
  // R3
  nmi_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_vld && nmi_id == ID_W'(1023) && !ack_vld) |-> !act_pulse);
  // R9
  rpr_nmi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpr_nmi |-> rpr_prio == '0);
  // R4
  peek_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_peek && !rd_ack && !rd_nmi) |=> ($stable(rpr_prio) && $stable(rpr_nmi) && !act_pulse));
  // R8
  rpr_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack || rd_nmi) |=> rpr_prio <= $past(rpr_prio));
  // R11
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |=> ack_vld);
endmodule

bind irq_ack_unit irq_ack_unit_chk #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_ack(rd_ack), .rd_nmi(rd_nmi), .rd_peek(rd_peek),
  .ack_vld(ack_vld), .ack_id(ack_id), .nmi_vld(nmi_vld), .nmi_id(nmi_id),
  .act_pulse(act_pulse), .act_id(act_id), .rpr_prio(rpr_prio), .rpr_nmi(rpr_nmi)
);

// File: tb/irq_ack_unit_test.sv
`timescale 1ns/1ps
module irq_ack_unit_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cpu_ns = 1'b1;
  logic [7:0] pmr = 8'hF0;
  logic pend_valid = 1'b0, pend_nmi = 1'b0;
  logic [9:0] pend_id = '0;
  logic [7:0] pend_prio = '0;
  logic [1:0] pend_grp = '0;
  logic rd_ack = 1'b0, rd_nmi = 1'b0, rd_peek = 1'b0;

  logic       av[2], nv[2], pv[2], ap[2], rn[2];
  logic [9:0] ai[2], ni[2], pi[2], aid[2];
  logic [7:0] rp[2];

  irq_ack_unit uut (
    .clk(clk), .rst_n(rst_n), .cpu_ns(cpu_ns), .pmr(pmr), .pend_valid(pend_valid),
    .pend_id(pend_id), .pend_prio(pend_prio), .pend_grp(pend_grp), .pend_nmi(pend_nmi),
    .rd_ack(rd_ack), .rd_nmi(rd_nmi), .rd_peek(rd_peek),
    .ack_vld(av[0]), .ack_id(ai[0]), .nmi_vld(nv[0]), .nmi_id(ni[0]),
    .peek_vld(pv[0]), .peek_id(pi[0]), .act_pulse(ap[0]), .act_id(aid[0]),
    .rpr_prio(rp[0]), .rpr_nmi(rn[0]));

  irq_ack_unit #(.SECURITY(1'b0), .CPU_NMI(1'b0)) uut_plain (
    .clk(clk), .rst_n(rst_n), .cpu_ns(cpu_ns), .pmr(pmr), .pend_valid(pend_valid),
    .pend_id(pend_id), .pend_prio(pend_prio), .pend_grp(pend_grp), .pend_nmi(pend_nmi),
    .rd_ack(rd_ack), .rd_nmi(rd_nmi), .rd_peek(rd_peek),
    .ack_vld(av[1]), .ack_id(ai[1]), .nmi_vld(nv[1]), .nmi_id(ni[1]),
    .peek_vld(pv[1]), .peek_id(pi[1]), .act_pulse(ap[1]), .act_id(aid[1]),
    .rpr_prio(rp[1]), .rpr_nmi(rn[1]));

  typedef struct {
    string      tag;
    logic       av, nv, pv, act, rn;
    logic [9:0] a, n, p, aid;
    logic [7:0] rp;
  } exp_t;

  exp_t q0[$], q1[$];
  int total = 0, bad = 0;
  logic [7:0] m_rpr[2];
  logic       m_nmi[2];
  bit         done = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model(int k, string tag, output exp_t e);
    bit sec = (k == 0);
    bit cn  = (k == 0);
    logic [1:0] ge, gt;
    logic [7:0] rpr;
    bit avail, pok, ne, tn, tm;
    ge = (!sec && pend_grp == 2'd1) ? 2'd0 : pend_grp;
    gt = (sec && !cpu_ns) ? 2'd1 : 2'd2;
    avail = pend_valid && pend_id < 10'd1020 && ge == gt;
    rpr = m_nmi[k] ? 8'h00 : m_rpr[k];
    pok = pend_prio < pmr && pend_prio < rpr;
    ne = cn && pend_nmi;
    tn = rd_ack && avail && pok && !ne;
    tm = rd_nmi && cn && avail && pok && ne;
    e.tag = tag;
    e.av = rd_ack; e.nv = rd_nmi; e.pv = rd_peek;
    e.a = !(avail && pok) ? 10'd1023 : (ne ? 10'd1022 : pend_id);
    e.n = (avail && pok && ne) ? pend_id : 10'd1023;
    e.p = avail ? pend_id : 10'd1023;
    e.act = tn || tm;
    e.aid = pend_id;
    if (tn && {pend_prio[7:3], 3'b000} < m_rpr[k]) m_rpr[k] = {pend_prio[7:3], 3'b000};
    if (tm) m_nmi[k] = 1'b1;
    e.rn = m_nmi[k];
    e.rp = m_nmi[k] ? 8'h00 : m_rpr[k];
  endtask

  task automatic rd(string tag, logic v, logic [9:0] id, logic [7:0] pr, logic [1:0] g,
                    logic nm, logic a, logic n, logic p);
    exp_t e0, e1;
    @(negedge clk);
    pend_valid = v; pend_id = id; pend_prio = pr; pend_grp = g; pend_nmi = nm;
    rd_ack = a; rd_nmi = n; rd_peek = p;
    model(0, tag, e0);
    model(1, tag, e1);
    q0.push_back(e0);
    q1.push_back(e1);
    @(negedge clk);
    rd_ack = 1'b0; rd_nmi = 1'b0; rd_peek = 1'b0;
  endtask

  task automatic compare(int k, exp_t e);
    chk(e.tag, "ack_vld", 32'(av[k]), 32'(e.av));
    chk(e.tag, "nmi_vld", 32'(nv[k]), 32'(e.nv));
    chk(e.tag, "peek_vld", 32'(pv[k]), 32'(e.pv));
    if (e.av) chk(e.tag, "ack_id", 32'(ai[k]), 32'(e.a));
    if (e.nv) chk(e.tag, "nmi_id", 32'(ni[k]), 32'(e.n));
    if (e.pv) chk(e.tag, "peek_id", 32'(pi[k]), 32'(e.p));
    chk(e.tag, "act_pulse", 32'(ap[k]), 32'(e.act));
    if (e.act) chk(e.tag, "act_id", 32'(aid[k]), 32'(e.aid));
    chk(e.tag, "rpr_prio", 32'(rp[k]), 32'(e.rp));
    chk(e.tag, "rpr_nmi", 32'(rn[k]), 32'(e.rn));
  endtask

  always @(negedge clk) begin
    if (rst_n && (av[0] || nv[0] || pv[0])) begin
      if (q0.size() == 0 || q1.size() == 0) begin
        total++; bad++;
        $display("FAIL R11 unexpected result act=1 exp=0");
      end else begin
        compare(0, q0.pop_front());
        compare(1, q1.pop_front());
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_rpr[0] = 8'hFF; m_rpr[1] = 8'hFF; m_nmi[0] = 1'b0; m_nmi[1] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk("R11 reset", "valids", 32'({av[k], nv[k], pv[k], ap[k]}), 32'h0);
      chk("R8 reset", "rpr_prio", 32'(rp[k]), 32'hFF);
      chk("R9 reset", "rpr_nmi", 32'(rn[k]), 32'h0);
    end
    rd("R4 peek", 1, 10'd40, 8'h80, 2'd2, 0, 0, 0, 1);
    rd("R7 mask", 1, 10'd41, 8'hF8, 2'd2, 0, 1, 0, 0);
    rd("R1 ack", 1, 10'd40, 8'h80, 2'd2, 0, 1, 0, 0);
    rd("R7 rpr strict", 1, 10'd42, 8'h80, 2'd2, 0, 1, 0, 0);
    rd("R2 nmi on normal", 1, 10'd43, 8'h60, 2'd2, 1, 1, 0, 1);
    rd("R3 plain on nmi", 1, 10'd44, 8'h40, 2'd2, 0, 0, 1, 0);
    rd("R6 grp0", 1, 10'd45, 8'h40, 2'd0, 0, 1, 0, 1);
    cpu_ns = 1'b0;
    rd("R6 grp1 secure", 1, 10'd46, 8'h55, 2'd1, 0, 1, 0, 1);
    cpu_ns = 1'b1;
    rd("R8 low bits", 1, 10'd48, 8'h4D, 2'd2, 0, 1, 0, 1);
    rd("R5 not valid", 0, 10'd50, 8'h10, 2'd2, 0, 1, 1, 1);
    rd("R5 special id", 1, 10'd1021, 8'h10, 2'd2, 0, 1, 1, 1);
    rd("R3 both ports", 1, 10'd47, 8'h30, 2'd2, 0, 1, 1, 1);
    rd("R10 nmi both ports", 1, 10'd60, 8'h28, 2'd2, 1, 1, 1, 0);
    rd("R9 nmi ack", 1, 10'd77, 8'h20, 2'd2, 1, 0, 1, 0);
    rd("R9 blocked", 1, 10'd78, 8'h08, 2'd2, 0, 1, 0, 0);
    rd("R4 peek after", 1, 10'd79, 8'h00, 2'd2, 1, 0, 0, 1);
    repeat (3) @(negedge clk);
    chk("R11 drain", "queue", 32'(q0.size()), 32'h0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule